// File: doc/BRIEF.md
# Serial-to-Parallel Word Framer with Boundary Slip

This block collects a serial bit stream, one bit per fast bit-clock cycle, into parallel words. The word width `W` is a parameter and may be 4, 8 or 10. A free-running bit counter marks one framing edge every `W` cycles. At each framing edge the block outputs one word and pulses a valid strobe for one cycle.

During link training, logic in a slower word-clock domain can move the word boundary. It raises a slip request. The block synchronizes that request into the bit-clock domain, detects its rising edge and holds one slip as pending. The slip takes effect at the next framing edge, where the block changes the boundary offset that selects the output window.

The rule for the new offset depends on the width:
- With `W = 4` the offset simply increments.
- With `W = 8` and `W = 10` the offset steps -3 and +1 in turn. This sequence still visits every alignment once per `W` slips.

Top module: `bitslip_deser`

## Requirements
- R1: While reset is asserted (`rst_n` low, asynchronous), `word_o` and `word_valid_o` are 0. Reset also clears the following, so that a fresh slip sequence starts from offset 0 with a -3 first step:
  - the boundary offset (to 0),
  - the bit counter,
  - any pending slip,
  - the synchronizer registers,
  - the step-direction flag (so that the next step is -3).
- R2: `word_valid_o` is high for exactly one cycle in every `W` bit-clock cycles, beginning after the `W`-th clock edge following reset release. At that edge, bit `i` of `word_o` is the serial bit received `2W-1-off-i` edges earlier, where the edge itself counts as 0 and `off` is the current offset. So bit 0 is the earliest received bit of the window.
- R3: Only a 0-to-1 transition of `slip_req_i` creates a slip. Holding the request high for any number of cycles produces no further slip.
- R4: The request passes through two synchronizer flops and a registered edge detector. The slip becomes pending on the fourth bit-clock edge after the rising request is first sampled, and it is applied at the next framing edge. The word emitted at that edge still uses the old offset.
- R5: At most one slip is applied per word. A rising edge whose pulse arrives while a slip is already pending is discarded.
- R6: With `W = 4` each applied slip moves the offset by +1 modulo 4 (0,1,2,3,0,...).
- R7: With `W = 8` the applied slips step the offset -3 and +1 in turn, modulo 8 (0,5,6,3,4,1,2,7,0,...).
- R8: With `W = 10` the applied slips step the offset -3 and +1 in turn, modulo 10 (0,7,8,5,6,3,4,1,2,9,0,...).
- R9: In the 8- and 10-bit widths the first slip after reset is always -3, and each later slip takes the opposite direction to the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Fast bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data bit |
| slip_req_i | input | 1 | Slip request from the word-clock domain, acts on its rising edge |
| word_o | output | W | Framed parallel word, bit 0 earliest received |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The output word and strobe are registered, so each one is due in the cycle after the framing edge that produced it. A slip request needs four edges before it is pending, and then waits for the next framing edge. Its effect therefore first shows in the word after the one emitted at that framing edge.

The bench model counts edges in exactly this way: it holds its own serial history, request history and offset as integers. It compares `word_o` and `word_valid_o` on every falling edge, half a cycle after the registers update. Each comparison therefore sees only settled values.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  // Offset reached by one applied slip.
  function automatic int slip_target(int off, bit minus_step, int width, bit alt_mode);
    if (alt_mode && minus_step) return (off + width - 3) % width;
    return (off + 1) % width;
  endfunction

  // Widths above four use the alternating -3/+1 walk.
  function automatic bit uses_alt(int width);
    return width > 4;
  endfunction

endpackage

// File: rtl/bsd_slip_sync.sv
module bsd_slip_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic pulse_o
);
  logic meta_q, sync_q, prev_q;
  logic rise;

  assign rise = sync_q & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      sync_q  <= 1'b0;
      prev_q  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      meta_q  <= req_i;
      sync_q  <= meta_q;
      prev_q  <= sync_q;
      pulse_o <= rise;
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/bsd_frame_shift.sv
module bsd_frame_shift #(
  parameter int W     = 8,
  parameter int OFF_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             frame_end_o,
  output logic [W-1:0]     word_o,
  output logic             valid_o
);
  localparam int SR_W  = 2 * W;
  localparam int CNT_W = $clog2(W);

  logic [SR_W-1:0]  sr_q, sr_next;
  logic [CNT_W-1:0] cnt_q;

  assign sr_next     = {sdata_i, sr_q[SR_W-1:1]};
  assign frame_end_o = (cnt_q == CNT_W'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      sr_q    <= sr_next;
      cnt_q   <= frame_end_o ? '0 : cnt_q + 1'b1;
      valid_o <= frame_end_o;
      if (frame_end_o) word_o <= sr_next[off_i +: W];
    end
  end

  assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(W - 1));

endmodule

// File: rtl/bsd_slip_ctrl.sv
module bsd_slip_ctrl #(
  parameter int W     = 8,
  parameter int OFF_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic             frame_end_i,
  output logic [OFF_W-1:0] off_o
);
  localparam bit ALT = bsd_pkg::uses_alt(W);

  logic pend_q;
  logic apply;
  logic minus_step;

  assign apply = pend_q & frame_end_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (pend_q) pend_q <= ~frame_end_i;
    else pend_q <= pulse_i;
  end

  generate
    if (ALT) begin : g_alt
      logic minus_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) minus_q <= 1'b1;
        else if (apply) minus_q <= ~minus_q;
      end
      assign minus_step = minus_q;

      assert_alternate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (minus_step != $past(minus_step)));
      assert_keep_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(minus_step));
    end else begin : g_inc
      assign minus_step = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_o <= '0;
    else if (apply)
      off_o <= OFF_W'(bsd_pkg::slip_target(int'(off_o), minus_step, W, ALT));
  end

  assert_offset_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(off_o));

  assert_offset_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !$stable(off_o));

  assert_offset_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    off_o <= OFF_W'(W - 1));

  assert_pending_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !pend_q);

endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
  parameter int W = 8
) (
  input  logic         clk_bit,
  input  logic         rst_n,
  input  logic         sdata_i,
  input  logic         slip_req_i,
  output logic [W-1:0] word_o,
  output logic         word_valid_o
);
  localparam int OFF_W = $clog2(W);

  logic             slip_pulse;
  logic             frame_end;
  logic [OFF_W-1:0] offset;

  bsd_slip_sync u_sync (
    .clk     (clk_bit),
    .rst_n   (rst_n),
    .req_i   (slip_req_i),
    .pulse_o (slip_pulse)
  );

  bsd_slip_ctrl #(.W(W), .OFF_W(OFF_W)) u_ctrl (
    .clk         (clk_bit),
    .rst_n       (rst_n),
    .pulse_i     (slip_pulse),
    .frame_end_i (frame_end),
    .off_o       (offset)
  );

  bsd_frame_shift #(.W(W), .OFF_W(OFF_W)) u_shift (
    .clk         (clk_bit),
    .rst_n       (rst_n),
    .sdata_i     (sdata_i),
    .off_i       (offset),
    .frame_end_o (frame_end),
    .word_o      (word_o),
    .valid_o     (word_valid_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_bit)
    !rst_n |-> (!word_valid_o && word_o == '0));

endmodule

// File: tb/bitslip_deser_tb.sv
module bitslip_deser_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0;
  logic req = 1'b0;
  logic [6:0] lfsr = 7'h5A;
  string tag = "R1";
  int cycles = 0;
  bit timeout = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    sdata <= lfsr[6];
    lfsr  <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    cycles <= cycles + 1;
  end

  genvar li;
  generate
    for (li = 0; li < 3; li++) begin : g_lane
      localparam int W = (li == 0) ? 4 : (li == 1) ? 8 : 10;
      localparam string MTAG = (li == 0) ? "R6" : (li == 1) ? "R7" : "R8";
      logic [W-1:0] dword;
      logic dvalid;
      int nchk = 0;
      int nbad = 0;

      bitslip_deser #(.W(W)) u_dut (
        .clk_bit(clk), .rst_n(rst_n), .sdata_i(sdata), .slip_req_i(req),
        .word_o(dword), .word_valid_o(dvalid)
      );

      int hist[0:31];
      int cnt, off, pend;
      int minus;
      int rq1, rq2, rq3, pq;
      logic [W-1:0] exp_word;
      logic exp_valid;

      always @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 0; k < 32; k++) hist[k] = 0;
          cnt = 0; off = 0; pend = 0; minus = 1;
          rq1 = 0; rq2 = 0; rq3 = 0; pq = 0;
          exp_word = '0; exp_valid = 1'b0;
        end else begin
          int pulse_now, frame;
          pulse_now = pq;
          pq = (rq2 == 1 && rq3 == 0) ? 1 : 0;
          rq3 = rq2; rq2 = rq1; rq1 = int'(req);
          for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
          hist[0] = int'(sdata);
          frame = (cnt == W - 1) ? 1 : 0;
          exp_valid = (frame == 1);
          if (frame == 1)
            for (int i = 0; i < W; i++) exp_word[i] = hist[2*W-1-off-i][0];
          if (pend == 1) begin
            if (frame == 1) begin
              pend = 0;
              if (W == 4) off = (off + 1) % W;
              else begin
                off = (minus == 1) ? (off + W - 3) % W : (off + 1) % W;
                minus = 1 - minus;
              end
            end
          end else pend = pulse_now;
          cnt = (frame == 1) ? 0 : cnt + 1;
        end
      end

      always @(negedge clk) begin
        nchk++;
        if (dvalid !== exp_valid || dword !== exp_word) begin
          nbad++;
          $display("FAIL %s %s W=%0d t=%0t: word=%h valid=%b expected word=%h valid=%b",
                   tag, MTAG, W, $time, dword, dvalid, exp_word, exp_valid);
        end
      end
    end
  endgenerate

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slip_once(input int hi, input int lo);
    @(negedge clk) req = 1'b1;
    wait_cyc(hi);
    req = 1'b0;
    wait_cyc(lo);
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    timeout = 1'b1;
  end

  initial begin
    tag = "R1";
    wait_cyc(5);
    rst_n = 1'b1;
    tag = "R2";
    wait_cyc(60);
    tag = "R4 R9";
    slip_once(30, 30);
    tag = "R3";
    slip_once(150, 30);
    tag = "R6 R7 R8";
    for (int s = 0; s < 11; s++) slip_once(25, 25);
    tag = "R5";
    for (int s = 0; s < 6; s++) begin
      @(negedge clk) req = 1'b1;
      wait_cyc(1); req = 1'b0;
      wait_cyc(1 + s);
    end
    wait_cyc(40);
    tag = "R1 R9";
    @(negedge clk) rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    slip_once(20, 40);
    tag = "R7 R8";
    slip_once(20, 40);
    finish_run();
  end

  always @(posedge timeout) finish_run();

  task automatic finish_run();
    int total, bad;
    total = g_lane[0].nchk + g_lane[1].nchk + g_lane[2].nchk;
    bad   = g_lane[0].nbad + g_lane[1].nbad + g_lane[2].nbad;
    if (timeout) begin
      total++; bad++;
      $display("FAIL watchdog R2: cycles=%0d expected below 100000", cycles);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

endmodule